// File: doc/BRIEF.md
# Code Address Patch Comparator Bank

This block watches the addresses of instruction and literal fetches and compares each one against a bank of programmable word-address comparators. When the lowest-numbered enabled comparator that matches is set to remap, the block gives an SRAM address. The fetch logic uses that address in place of the original one, so fixed code can be patched without rewriting it. When that comparator is set to a breakpoint mode, the block raises a breakpoint request, but only if the halfword being fetched is one that the mode covers.

Software configures the bank through a small word-indexed register port. The port holds a control word, a remap base and one configuration word per comparator. Writes to the control word are accepted only when a key bit is set in the written data. The bus fabric, the SRAM and the halt logic sit outside this block. The fetch result appears on registered outputs one clock after the fetch address is presented.

Top module: `code_patch_bank`

## Requirements
- R1: A write to register index 0 (control) changes the global enable (bit 0) only when bit 1 of the write data is 1; any other control write leaves the stored state unchanged.
- R2: A control read returns the global enable in bit 0, zero in bit 1, the code comparator count 6 in bits 7:4, the literal comparator count 2 in bits 11:8, zero in bits 14:12, and zero in every other bit.
- R3: Register index 1 (remap base) reads back 3'b001 in bits 31:29, the written bits 28:5, and zero in bits 4:0.
- R4: Register index 2+n configures comparator n: bits 31:30 hold the mode, bits 28:2 the word address, and bit 0 the enable; bits 29 and 1 read as zero.
- R5: A comparator matches only when fetch_valid is high, its own enable and the global enable are both set, and fetch address bits 28:2 equal its stored word address.
- R6: Only fetch addresses whose bits 31:29 are 3'b000 can match.
- R7: When the winning comparator acts as a remap (mode 2'b00), remap_valid rises one cycle later. remap_addr is then {3'b001, base[28:5], 5'b0} plus 4 times the comparator index plus fetch address bits 1:0.
- R8: Mode 2'b01 breaks on the lower halfword (address bit 1 = 0) only. Mode 2'b10 breaks on the upper halfword (bit 1 = 1) only. Mode 2'b11 breaks on both. A break sets bkpt_req one cycle after the fetch, and remap_valid stays low.
- R9: Comparators 6 and 7 always act as remap comparators, whatever their mode field holds.
- R10: When several comparators match, only the lowest-numbered one decides the result, even when its breakpoint mode does not cover the fetched halfword.
- R11: After reset, every comparator and the global enable are cleared, the remap base field is zero, and both result outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Fetch byte address |
| remap_valid | output | 1 | Previous fetch is redirected |
| remap_addr | output | 32 | Redirected SRAM byte address |
| bkpt_req | output | 1 | Previous fetch hit a breakpoint |

## Verification
A register write takes effect at the clock edge that samples the strobe. Register reads are combinational, so the bench reads them one half cycle after it sets the index. A fetch result is registered once, so it is due at the first rising edge after the fetch is presented. The bench drives every fetch at a falling edge and samples remap_valid, remap_addr and bkpt_req at the next falling edge. By that point exactly one register stage has passed and the fetch has already been withdrawn. The sweep covers every comparator, mode and halfword.

// File: rtl/cpb_pkg.sv
package cpb_pkg;

    typedef enum logic [1:0] {
        MODE_REMAP   = 2'b00,
        MODE_BK_LO   = 2'b01,
        MODE_BK_HI   = 2'b10,
        MODE_BK_BOTH = 2'b11
    } cmp_mode_e;

    typedef struct packed {
        cmp_mode_e   mode;
        logic [26:0] word;
        logic        en;
    } cmp_cfg_t;

    localparam int REG_CTRL  = 0;
    localparam int REG_REMAP = 1;
    localparam int REG_CMP0  = 2;

    localparam logic [2:0] CODE_TOP = 3'b000;
    localparam logic [2:0] SRAM_TOP = 3'b001;

    function automatic logic [31:0] pack_cmp(input cmp_cfg_t c);
        return {c.mode, 1'b0, c.word, 1'b0, c.en};
    endfunction

    function automatic cmp_cfg_t unpack_cmp(input logic [31:0] d);
        cmp_cfg_t c;
        c.mode = cmp_mode_e'(d[31:30]);
        c.word = d[28:2];
        c.en   = d[0];
        return c;
    endfunction

    function automatic logic half_covered(input cmp_mode_e m, input logic upper);
        return (m == MODE_BK_BOTH) || (m == MODE_BK_LO && !upper) ||
               (m == MODE_BK_HI && upper);
    endfunction

endpackage

// File: rtl/cpb_regs.sv
module cpb_regs
    import cpb_pkg::*;
#(
    parameter int NUM_CMP = 8,
    parameter int NUM_LIT = 2,
    parameter int ADDR_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output logic                      glb_en,
    output logic [23:0]               base,
    output cmp_cfg_t [NUM_CMP-1:0]    cfg
);
    localparam int NUM_CODE = NUM_CMP - NUM_LIT;

    logic                   glb_en_q;
    logic [23:0]            base_q;
    cmp_cfg_t [NUM_CMP-1:0] cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            glb_en_q <= 1'b0;
            base_q   <= '0;
            cfg_q    <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(REG_CTRL) && wdata[1])
                glb_en_q <= wdata[0];
            if (addr == ADDR_W'(REG_REMAP))
                base_q <= wdata[28:5];
            for (int k = 0; k < NUM_CMP; k++) begin
                if (addr == ADDR_W'(REG_CMP0 + k))
                    cfg_q[k] <= unpack_cmp(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(REG_CTRL))
            rdata = {17'b0, 3'b000, 4'(NUM_LIT), 4'(NUM_CODE), 2'b00, 1'b0, glb_en_q};
        else if (addr == ADDR_W'(REG_REMAP))
            rdata = {SRAM_TOP, base_q, 5'b0};
        for (int k = 0; k < NUM_CMP; k++) begin
            if (addr == ADDR_W'(REG_CMP0 + k))
                rdata = pack_cmp(cfg_q[k]);
        end
    end

    assign glb_en = glb_en_q;
    assign base   = base_q;
    assign cfg    = cfg_q;

endmodule

// File: rtl/cpb_match.sv
module cpb_match
    import cpb_pkg::*;
#(
    parameter int IDX      = 0,
    parameter int NUM_CODE = 6
) (
    input  cmp_cfg_t    cfg,
    input  logic        glb_en,
    input  logic        fetch_valid,
    input  logic [31:0] fetch_addr,
    output logic        hit,
    output logic        brk,
    output logic        half_ok
);
    assign hit = fetch_valid && glb_en && cfg.en &&
                 (fetch_addr[31:29] == CODE_TOP) &&
                 (fetch_addr[28:2] == cfg.word);

    generate
        if (IDX < NUM_CODE) begin : g_full
            assign brk     = (cfg.mode != MODE_REMAP);
            assign half_ok = half_covered(cfg.mode, fetch_addr[1]);
        end else begin : g_remap_only
            assign brk     = 1'b0;
            assign half_ok = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/cpb_select.sv
module cpb_select
    import cpb_pkg::*;
#(
    parameter int NUM_CMP = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CMP-1:0] hit,
    input  logic [NUM_CMP-1:0] brk,
    input  logic [NUM_CMP-1:0] half_ok,
    input  logic [23:0]        base,
    input  logic [1:0]         byte_off,
    output logic               remap_valid,
    output logic [31:0]        remap_addr,
    output logic               bkpt_req
);
    localparam int IW = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1;

    logic          win;
    logic [IW-1:0] win_idx;
    logic          nxt_remap;
    logic          nxt_bkpt;
    logic [31:0]   nxt_addr;

    always_comb begin
        win     = 1'b0;
        win_idx = '0;
        for (int k = NUM_CMP - 1; k >= 0; k--) begin
            if (hit[k]) begin
                win     = 1'b1;
                win_idx = IW'(k);
            end
        end
        nxt_remap = win && !brk[win_idx];
        nxt_bkpt  = win && brk[win_idx] && half_ok[win_idx];
        nxt_addr  = {SRAM_TOP, base, 5'b0} + (32'(win_idx) << 2) + 32'(byte_off);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remap_valid <= 1'b0;
            remap_addr  <= '0;
            bkpt_req    <= 1'b0;
        end else begin
            remap_valid <= nxt_remap;
            remap_addr  <= nxt_remap ? nxt_addr : '0;
            bkpt_req    <= nxt_bkpt;
        end
    end

endmodule

// File: rtl/code_patch_bank.sv
module code_patch_bank
    import cpb_pkg::*;
#(
    parameter int NUM_CMP = 8,
    parameter int NUM_LIT = 2,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fetch_valid,
    input  logic [31:0]       fetch_addr,
    output logic              remap_valid,
    output logic [31:0]       remap_addr,
    output logic              bkpt_req
);
    localparam int NUM_CODE = NUM_CMP - NUM_LIT;

    logic                   glb_en;
    logic [23:0]            base;
    cmp_cfg_t [NUM_CMP-1:0] cfg;
    logic [NUM_CMP-1:0]     hit;
    logic [NUM_CMP-1:0]     brk;
    logic [NUM_CMP-1:0]     half_ok;

    cpb_regs #(.NUM_CMP(NUM_CMP), .NUM_LIT(NUM_LIT), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .glb_en (glb_en),
        .base   (base),
        .cfg    (cfg)
    );

    generate
        for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
            cpb_match #(.IDX(g), .NUM_CODE(NUM_CODE)) u_match (
                .cfg         (cfg[g]),
                .glb_en      (glb_en),
                .fetch_valid (fetch_valid),
                .fetch_addr  (fetch_addr),
                .hit         (hit[g]),
                .brk         (brk[g]),
                .half_ok     (half_ok[g])
            );
        end
    endgenerate

    cpb_select #(.NUM_CMP(NUM_CMP)) u_sel (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .brk         (brk),
        .half_ok     (half_ok),
        .base        (base),
        .byte_off    (fetch_addr[1:0]),
        .remap_valid (remap_valid),
        .remap_addr  (remap_addr),
        .bkpt_req    (bkpt_req)
    );

endmodule

// File: rtl/cpb_checker.sv
module cpb_checker #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              glb_en,
    input logic              fetch_valid,
    input logic [31:0]       fetch_addr,
    input logic              remap_valid,
    input logic [31:0]       remap_addr,
    input logic              bkpt_req
);
    p_key_gate_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_addr == '0 && !reg_wdata[1]) |=> $stable(glb_en));

    p_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> (!remap_valid && !bkpt_req));

    p_gen_off_r5: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> (!remap_valid && !bkpt_req));

    p_code_only_r6: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_addr[31:29] != 3'b000) |=> (!remap_valid && !bkpt_req));

    p_sram_region_r7: assert property (@(posedge clk) disable iff (rst)
        remap_valid |-> remap_addr[31:29] == 3'b001);

    p_byte_off_r7: assert property (@(posedge clk) disable iff (rst)
        remap_valid |-> remap_addr[1:0] == $past(fetch_addr[1:0]));

    p_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        !(remap_valid && bkpt_req));

endmodule

bind code_patch_bank cpb_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .glb_en      (glb_en),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .remap_valid (remap_valid),
    .remap_addr  (remap_addr),
    .bkpt_req    (bkpt_req)
);

// File: tb/code_patch_bank_tb.sv
module code_patch_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        remap_valid;
    logic [31:0] remap_addr;
    logic        bkpt_req;

    int total = 0;
    int bad   = 0;

    localparam logic [31:0] BASE_WR = 32'h5ABC_DE7F;

    always #4 clk = ~clk;

    code_patch_bank u_dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .remap_valid(remap_valid), .remap_addr(remap_addr), .bkpt_req(bkpt_req)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Presents one fetch, samples the registered result one cycle later.
    task automatic fetch(input logic [31:0] a, input string req,
                         input logic exp_rv, input logic [31:0] exp_ra, input logic exp_bk);
        @(negedge clk);
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        check({req, " remap_valid"}, {31'b0, remap_valid}, {31'b0, exp_rv});
        check({req, " remap_addr"}, exp_rv ? remap_addr : 32'h0, exp_ra);
        check({req, " bkpt_req"}, {31'b0, bkpt_req}, {31'b0, exp_bk});
    endtask

    function automatic logic [26:0] word_of(input int i);
        return 27'h0012_340 + 27'(i * 13);
    endfunction

    function automatic logic [31:0] remap_exp(input int i, input logic [1:0] off);
        return ((BASE_WR & 32'h1FFF_FFE0) | 32'h2000_0000) + 32'(i * 4) + 32'(off);
    endfunction

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] a;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 / R2 / R3 / R4 reset state
        check("R11 remap_valid", {31'b0, remap_valid}, 32'h0);
        check("R11 bkpt_req", {31'b0, bkpt_req}, 32'h0);
        rd(4'd0, d); check("R2 R11 ctrl reset", d, 32'h0000_0260);
        rd(4'd1, d); check("R3 R11 remap reset", d, 32'h2000_0000);
        for (int i = 0; i < 8; i++) begin
            rd(4'(2 + i), d); check("R4 R11 cmp reset", d, 32'h0);
        end

        // R1 key gate
        wr(4'd0, 32'h0000_0001);
        rd(4'd0, d); check("R1 no key ignored", d, 32'h0000_0260);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, d); check("R1 R2 keyed write", d, 32'h0000_0261);
        wr(4'd0, 32'h0000_0000);
        rd(4'd0, d); check("R1 unkeyed clear ignored", d, 32'h0000_0261);

        // R3 remap base
        wr(4'd1, BASE_WR);
        rd(4'd1, d); check("R3 remap readback", d, (BASE_WR & 32'h1FFF_FFE0) | 32'h2000_0000);

        // R4 layout with reserved bits written to 1
        wr(4'd3, 32'hFFFF_FFFF);
        rd(4'd3, d); check("R4 cmp layout", d, 32'hDFFF_FFFD);
        wr(4'd3, 32'h0);

        // R7 R8 R9 sweep: every comparator, mode and halfword
        for (int i = 0; i < 8; i++) begin
            for (int m = 0; m < 4; m++) begin
                for (int h = 0; h < 2; h++) begin
                    logic eff_remap;
                    logic eb;
                    eff_remap = (m == 0) || (i >= 6);
                    eb = !eff_remap && ((m == 3) || (m == 1 && h == 0) || (m == 2 && h == 1));
                    wr(4'(2 + i), {2'(m), 1'b0, word_of(i), 1'b0, 1'b1});
                    a = {3'b000, word_of(i), 1'(h), 1'(h)};
                    fetch(a, (i >= 6) ? "R9 sweep" : (m == 0 ? "R7 sweep" : "R8 sweep"),
                          eff_remap, eff_remap ? remap_exp(i, {1'(h), 1'(h)}) : 32'h0, eb);
                    wr(4'(2 + i), 32'h0);
                end
            end
        end

        // R5 comparator enable off
        wr(4'd2, {2'b00, 1'b0, word_of(0), 1'b0, 1'b0});
        fetch({3'b000, word_of(0), 2'b00}, "R5 cmp disabled", 1'b0, 32'h0, 1'b0);
        // R5 word mismatch
        wr(4'd2, {2'b00, 1'b0, word_of(0), 1'b0, 1'b1});
        fetch({3'b000, word_of(0) + 27'd1, 2'b00}, "R5 mismatch", 1'b0, 32'h0, 1'b0);
        // R6 outside code region
        fetch({3'b010, word_of(0), 2'b00}, "R6 region", 1'b0, 32'h0, 1'b0);
        fetch({3'b000, word_of(0), 2'b00}, "R5 hit", 1'b1, remap_exp(0, 2'b00), 1'b0);
        // R5 global enable off
        wr(4'd0, 32'h0000_0002);
        fetch({3'b000, word_of(0), 2'b00}, "R5 global off", 1'b0, 32'h0, 1'b0);
        wr(4'd0, 32'h0000_0003);
        wr(4'd2, 32'h0);

        // R10 priority
        wr(4'd4, {2'b00, 1'b0, word_of(9), 1'b0, 1'b1});
        wr(4'd7, {2'b11, 1'b0, word_of(9), 1'b0, 1'b1});
        fetch({3'b000, word_of(9), 2'b00}, "R10 low wins remap", 1'b1, remap_exp(2, 2'b00), 1'b0);
        wr(4'd3, {2'b01, 1'b0, word_of(9), 1'b0, 1'b1});
        fetch({3'b000, word_of(9), 2'b10}, "R10 low wins no break", 1'b0, 32'h0, 1'b0);
        fetch({3'b000, word_of(9), 2'b00}, "R10 low wins break", 1'b0, 32'h0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule